// File: doc/BRIEF.md
# Shift, Swap and Sign-Extend Unit

This unit carries out the four single-operand operations of a 20-bit-capable processor core that rewrite their operand in place. The four operations are rotate right through carry, arithmetic shift right, byte exchange and sign extension. The caller supplies the operand, the current carry flag, a byte/word select, a flag that marks the operand as a register, and a two-bit operation code. The unit returns the new operand value, the V, N, Z and C flag values, and one enable per flag. The enables tell the status register which flags to overwrite.

The operation logic is purely combinational. Its outputs pass through one register stage, so a request accepted on one rising edge of `clk` appears at the outputs after that edge. The outputs keep their last value until the next accepted request. Decode, stack handling and memory access are done elsewhere in the core. No operation reads operand bits above bit 15, so the operand input is 16 bits wide and the result is 20 bits wide.

Top module: `sxu_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, `out_valid`, `result`, all flag values and all flag enables are cleared to 0.
- R2: A request with `in_valid` high at a rising edge sets `out_valid` high after that edge. With `in_valid` low, `out_valid` is low after the edge.
- R3: Operation code 0 rotates right through carry. In word mode the result is carry_in in bit 15 and operand bits 15:1 in bits 14:0. In byte mode the result is carry_in in bit 7 and operand bits 7:1 in bits 6:0.
- R4: Operation code 1 is an arithmetic shift right. The top bit of the active width (bit 15 for a word, bit 7 for a byte) keeps its value, and the lower bits take the operand shifted right by one.
- R5: Both shift operations enable all four flags. They set V to 0 and C to operand bit 0. N is the top bit of the active width of the result, and Z is 1 when the active width of the result is all zeros.
- R6: In byte mode, both shift operations drive result bits 19:8 to 0. In word mode, they drive result bits 19:16 to 0.
- R7: Operation code 2 exchanges operand bits 15:8 with bits 7:0 and sets result bits 19:16 to 0. The byte/word select has no effect on it. All flag enables and all flag values are 0.
- R8: Operation code 3 sign-extends. Result bits 7:0 equal operand bits 7:0. If the register-mode input is 1, operand bit 7 is copied into result bits 19:8.
- R9: When sign extension runs with the register-mode input at 0, operand bit 7 is copied into bits 15:8 only, and bits 19:16 are 0.
- R10: Sign extension enables all four flags. V is 0, N is result bit 15, Z is 1 when result bits 15:0 are zero, and C is the inverse of Z. The byte/word select has no effect on it.
- R11: With `in_valid` low at a rising edge, `result` and all flag outputs keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe, one operation per cycle |
| op | input | 2 | 0 rotate-through-carry, 1 arithmetic shift, 2 byte exchange, 3 sign extend |
| byte_mode | input | 1 | 1 selects the 8-bit width for the shift operations |
| reg_mode | input | 1 | 1 when the operand is a register (sign extension reaches bit 19) |
| operand | input | 16 | Destination operand value |
| carry_in | input | 1 | Current C flag |
| out_valid | output | 1 | Result registered for the last request |
| result | output | 20 | New operand value |
| flag_v | output | 1 | New V value |
| flag_n | output | 1 | New N value |
| flag_z | output | 1 | New Z value |
| flag_c | output | 1 | New C value |
| upd_v | output | 1 | Write enable for V |
| upd_n | output | 1 | Write enable for N |
| upd_z | output | 1 | Write enable for Z |
| upd_c | output | 1 | Write enable for C |

## Verification
The only state in the unit is the single output register stage. A fault there, such as a wrong hold or capture decision, shows up one cycle after the request: either a stale result appears next to a fresh `out_valid`, or the outputs change while the unit is idle. Faults in the combinational paths show up in that same cycle as a wrong bit: the wrong MSB fill, the wrong width for N or Z, or a flag enable that is set during a byte exchange. The bench therefore runs every operation at both widths, with carry-in of 0 and 1 and with operands that have bit 7 and bit 15 set. It also checks that idle cycles leave the outputs unchanged.

// File: rtl/sxu_pkg.sv
// Shared definitions for the shift, swap and sign-extend unit.
// Assumes a 2-bit operation code. The shift operations depend on the
// order of the codes (the low bit selects arithmetic versus rotate).
package sxu_pkg;

    typedef enum logic [1:0] {
        OP_RRC  = 2'd0,
        OP_RRA  = 2'd1,
        OP_SWAP = 2'd2,
        OP_SEXT = 2'd3
    } sxu_op_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } sxu_flags_t;

endpackage

// File: rtl/sxu_shift.sv
// Right shift by one bit, either rotate through carry or arithmetic.
// Works on the low BYTE_W bits or on the full WORD_W bits.
// Assumes WORD_W >= BYTE_W >= 2. Result bits above the active width are 0.
module sxu_shift #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] operand,
    input  logic              carry_in,
    input  logic              byte_mode,
    input  logic              arith,
    output logic [WORD_W-1:0] result,
    output logic              carry_out
);

    logic msb_word;
    logic msb_byte;

    // Purpose: choose the value that fills the top bit of each width.
    always_comb begin
        msb_word = arith ? operand[WORD_W-1] : carry_in;
        msb_byte = arith ? operand[BYTE_W-1] : carry_in;
    end

    // Purpose: shift within the active width and clear the bits above it.
    always_comb begin
        result = '0;
        if (byte_mode)
            result[BYTE_W-1:0] = {msb_byte, operand[BYTE_W-1:1]};
        else
            result = {msb_word, operand[WORD_W-1:1]};
        carry_out = operand[0];
    end

endmodule

// File: rtl/sxu_swap_ext.sv
// Byte exchange and sign extension.
// Byte exchange swaps the two low bytes. Sign extension copies bit
// BYTE_W-1 upward: as far as DATA_W-1 for a register operand, and
// only up to WORD_W-1 otherwise.
// Assumes DATA_W > WORD_W = 2*BYTE_W.
module sxu_swap_ext #(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16,
    parameter int DATA_W = 20
) (
    input  logic [WORD_W-1:0] operand,
    input  logic              reg_mode,
    input  logic              sext,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] ext_val;
    logic              sign_bit;

    assign sign_bit = operand[BYTE_W-1];

    // Purpose: build the extended value one bit at a time. Bits up to
    // WORD_W-1 always take the sign; higher bits take it only for a register.
    assign ext_val[BYTE_W-1:0] = operand[BYTE_W-1:0];
    for (genvar i = BYTE_W; i < DATA_W; i++) begin : g_ext
        if (i < WORD_W) begin : g_word
            assign ext_val[i] = sign_bit;
        end else begin : g_wide
            assign ext_val[i] = sign_bit & reg_mode;
        end
    end

    // Purpose: pick the extended value or the byte-exchanged value.
    always_comb begin
        result = '0;
        if (sext)
            result = ext_val;
        else
            result[WORD_W-1:0] = {operand[BYTE_W-1:0], operand[WORD_W-1:BYTE_W]};
    end

endmodule

// File: rtl/sxu_flag_gen.sv
// Computes the flag values and flag enables from the result and the
// operation code. N and Z use the byte width only for shifts in byte mode.
// Assumes the value passed in is the low WORD_W bits of the result.
module sxu_flag_gen
    import sxu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int WORD_W = 16
) (
    input  sxu_op_e           op,
    input  logic              byte_mode,
    input  logic [WORD_W-1:0] res_low,
    input  logic              shift_carry,
    output sxu_flags_t        flags,
    output sxu_flags_t        upd
);

    logic narrow;
    logic n_bit;
    logic z_bit;

    // Purpose: take the sign and zero tests over the active width.
    always_comb begin
        narrow = byte_mode && (op == OP_RRC || op == OP_RRA);
        n_bit  = narrow ? res_low[BYTE_W-1] : res_low[WORD_W-1];
        z_bit  = narrow ? ~|res_low[BYTE_W-1:0] : ~|res_low;
    end

    // Purpose: apply the flag rules of each operation.
    always_comb begin
        flags = '0;
        upd   = '0;
        unique case (op)
            OP_RRC, OP_RRA: begin
                flags = '{v: 1'b0, n: n_bit, z: z_bit, c: shift_carry};
                upd   = '{v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
            end
            OP_SWAP: begin
                flags = '0;
                upd   = '0;
            end
            OP_SEXT: begin
                flags = '{v: 1'b0, n: n_bit, z: z_bit, c: ~z_bit};
                upd   = '{v: 1'b1, n: 1'b1, z: 1'b1, c: 1'b1};
            end
            default: begin
                flags = '0;
                upd   = '0;
            end
        endcase
    end

endmodule

// File: rtl/sxu_top.sv
// Top level of the shift, swap and sign-extend unit. It combines the shift
// path, the swap/extend path and the flag generator, and registers the
// outputs in one stage. Outputs hold while no request is presented.
// Assumes a synchronous active-low reset and one request per cycle.
module sxu_top
    import sxu_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DATA_W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          op,
    input  logic                byte_mode,
    input  logic                reg_mode,
    input  logic [2*BYTE_W-1:0] operand,
    input  logic                carry_in,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                flag_v,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_c,
    output logic                upd_v,
    output logic                upd_n,
    output logic                upd_z,
    output logic                upd_c
);

    localparam int WORD_W = 2 * BYTE_W;

    sxu_op_e           op_e;
    logic [WORD_W-1:0] shift_res;
    logic              shift_carry;
    logic [DATA_W-1:0] se_res;
    logic [DATA_W-1:0] comb_res;
    sxu_flags_t        comb_flags;
    sxu_flags_t        comb_upd;
    sxu_flags_t        flags_q;
    sxu_flags_t        upd_q;
    sxu_op_e           op_q;
    logic              byte_q;

    assign op_e = sxu_op_e'(op);

    sxu_shift #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_shift (
        .operand   (operand),
        .carry_in  (carry_in),
        .byte_mode (byte_mode),
        .arith     (op[0]),
        .result    (shift_res),
        .carry_out (shift_carry)
    );

    sxu_swap_ext #(.BYTE_W(BYTE_W), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_swap_ext (
        .operand  (operand),
        .reg_mode (reg_mode),
        .sext     (op[0]),
        .result   (se_res)
    );

    // Purpose: select the result of the path that op addresses.
    always_comb begin
        comb_res = '0;
        if (op[1])
            comb_res = se_res;
        else
            comb_res[WORD_W-1:0] = shift_res;
    end

    sxu_flag_gen #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) u_flags (
        .op          (op_e),
        .byte_mode   (byte_mode),
        .res_low     (comb_res[WORD_W-1:0]),
        .shift_carry (shift_carry),
        .flags       (comb_flags),
        .upd         (comb_upd)
    );

    // Purpose: register the outputs on a request and hold them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flags_q   <= '0;
            upd_q     <= '0;
            op_q      <= OP_RRC;
            byte_q    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= comb_res;
                flags_q <= comb_flags;
                upd_q   <= comb_upd;
                op_q    <= op_e;
                byte_q  <= byte_mode;
            end
        end
    end

    assign flag_v = flags_q.v;
    assign flag_n = flags_q.n;
    assign flag_z = flags_q.z;
    assign flag_c = flags_q.c;
    assign upd_v  = upd_q.v;
    assign upd_n  = upd_q.n;
    assign upd_z  = upd_q.z;
    assign upd_c  = upd_q.c;

    // R2: a request produces a valid output one edge later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2: an idle cycle produces no valid output
    a_r2_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R11: outputs hold while idle
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(flags_q) && $stable(upd_q)));

    // R5: shifts clear V and enable all flags
    a_r5_shift_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !op_q[1]) |-> (!flag_v && upd_v && upd_n && upd_z && upd_c));

    // R6: a byte-mode shift leaves the upper bits at zero
    a_r6_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !op_q[1] && byte_q) |-> (result[DATA_W-1:BYTE_W] == '0));

    // R7: byte exchange touches no flag
    a_r7_swap_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OP_SWAP) |-> ($countones({upd_v, upd_n, upd_z, upd_c}) == 0
                                            && result[DATA_W-1:WORD_W] == '0));

    // R10: sign extension sets C as the inverse of Z
    a_r10_sext_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && op_q == OP_SEXT) |-> (flag_c == !flag_z && !flag_v));

endmodule

// File: tb/tb_sxu_top.sv
// Scoreboard bench: the driver pushes expected items into a queue, and the
// monitor pops and compares one item for each valid output.
module tb_sxu_top;

    typedef struct packed {
        logic [19:0] res;
        logic [3:0]  flg;   // {v,n,z,c}
        logic [3:0]  upd;   // {v,n,z,c}
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'd0;
    logic        byte_mode = 1'b0;
    logic        reg_mode = 1'b0;
    logic [15:0] operand = 16'h0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [19:0] result;
    logic        flag_v, flag_n, flag_z, flag_c;
    logic        upd_v, upd_n, upd_z, upd_c;

    int   errors = 0;
    int   checks = 0;
    exp_t sb_q[$];
    logic [19:0] last_res = '0;
    bit   done = 0;

    always #4 clk = ~clk;   // 125 MHz

    sxu_top dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .byte_mode(byte_mode), .reg_mode(reg_mode), .operand(operand),
        .carry_in(carry_in), .out_valid(out_valid), .result(result),
        .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
        .upd_v(upd_v), .upd_n(upd_n), .upd_z(upd_z), .upd_c(upd_c)
    );

    // Reference model built from R3-style rules with integer arithmetic
    function automatic exp_t model(input logic [1:0] o, input logic bm, input logic rm,
                                   input logic [15:0] a, input logic ci);
        exp_t e;
        int   w;
        int   top;
        int   v;
        int   mask;
        e = '0;
        w = (bm && o < 2) ? 8 : 16;
        mask = (1 << w) - 1;
        top  = (w == 8) ? 32'h80 : 32'h8000;
        case (o)
            2'd0, 2'd1: begin
                v = (int'(a) & mask) >> 1;
                if (o == 2'd0) v = v | (ci ? top : 0);
                else           v = v | (int'(a) & top);
                e.res = 20'(v);
                e.flg = {1'b0, (v & top) != 0, v == 0, a[0]};
                e.upd = 4'hF;
            end
            2'd2: begin
                e.res = 20'(((int'(a) & 32'hFF) * 256) + (int'(a) / 256));
            end
            default: begin
                v = int'(a) & 32'hFF;
                if (a[7]) v = v + (rm ? 32'hFFF00 : 32'hFF00);
                e.res = 20'(v);
                e.flg = {1'b0, (v & 32'h8000) != 0, (v & 32'hFFFF) == 0,
                         (v & 32'hFFFF) != 0};
                e.upd = 4'hF;
            end
        endcase
        return e;
    endfunction

    task automatic drive(input logic [1:0] o, input logic bm, input logic rm,
                         input logic [15:0] a, input logic ci);
        @(negedge clk);
        op = o; byte_mode = bm; reg_mode = rm; operand = a; carry_in = ci;
        in_valid = 1'b1;
        sb_q.push_back(model(o, bm, rm, a, ci));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            operand  = ~operand;
            carry_in = ~carry_in;
        end
    endtask

    // Monitor: compare each valid output with the oldest expected item
    always @(negedge clk) begin
        #1;
        if (rst_n && out_valid) begin
            exp_t e;
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL R2: valid output with empty scoreboard, result=%h expected none", result);
            end else begin
                e = sb_q.pop_front();
                last_res = e.res;
                if (result !== e.res || {flag_v, flag_n, flag_z, flag_c} !== e.flg
                    || {upd_v, upd_n, upd_z, upd_c} !== e.upd) begin
                    errors++;
                    $display("FAIL R3-R10 op=%0d: res=%h flg=%b upd=%b expected res=%h flg=%b upd=%b",
                             dut.op_q, result, {flag_v, flag_n, flag_z, flag_c},
                             {upd_v, upd_n, upd_z, upd_c}, e.res, e.flg, e.upd);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    logic [15:0] pats[6] = '{16'h8081, 16'h0001, 16'h00FE, 16'h7F80, 16'h0000, 16'hC3A5};

    initial begin
        // R1: reset clears outputs
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== 20'h0 ||
            {flag_v, flag_n, flag_z, flag_c, upd_v, upd_n, upd_z, upd_c} !== 8'h00) begin
            errors++;
            $display("FAIL R1: out_valid=%b result=%h expected 0 and 00000", out_valid, result);
        end
        rst_n = 1'b1;
        idle(2);

        // R3, R4, R5, R6: both shifts, both widths, both carries
        for (int o = 0; o < 2; o++)
            for (int bm = 0; bm < 2; bm++)
                for (int ci = 0; ci < 2; ci++)
                    for (int p = 0; p < 6; p++)
                        drive(2'(o), 1'(bm), 1'b0, pats[p], 1'(ci));
        idle(3);

        // R7: byte exchange at both widths, flags untouched
        drive(2'd2, 1'b0, 1'b0, 16'h12F0, 1'b1);
        drive(2'd2, 1'b1, 1'b1, 16'h12F0, 1'b0);
        drive(2'd2, 1'b1, 1'b0, 16'h8001, 1'b1);
        drive(2'd2, 1'b0, 1'b1, 16'h0000, 1'b0);

        // R8, R9, R10: sign extension in register and memory mode
        drive(2'd3, 1'b0, 1'b1, 16'h0080, 1'b0);
        drive(2'd3, 1'b0, 1'b0, 16'h0080, 1'b1);
        drive(2'd3, 1'b1, 1'b1, 16'h017F, 1'b0);
        drive(2'd3, 1'b0, 1'b0, 16'hFF00, 1'b1);
        drive(2'd3, 1'b1, 1'b0, 16'h80FF, 1'b0);
        drive(2'd3, 1'b0, 1'b1, 16'h0000, 1'b1);
        idle(3);

        // R11: idle cycles with changing inputs leave the result unchanged
        drive(2'd0, 1'b0, 1'b0, 16'hA5A5, 1'b1);
        idle(1);
        op = 2'd3; reg_mode = 1'b1;
        idle(4);
        @(negedge clk);
        #2;
        checks++;
        if (result !== last_res || out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R11: result=%h out_valid=%b expected %h and 0", result, out_valid, last_res);
        end

        // R2: scoreboard drained means every request produced one output
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d items left expected 0", sb_q.size());
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule